// File: doc/BRIEF.md
# SPI Buffer and Interrupt Controller

This block sits between a register-style bus port and a serial shift engine. It holds a 16-entry queue in each direction. The receive queue is filled by the engine and drained by bus reads. The transmit queue is filled by bus writes and drained by the engine. Each queue keeps a 5-bit fill count, and the block compares that count against a programmable threshold to raise an interrupt flag.

The block has two interrupt schemes, selected by a mode bit. In queued mode it drives two separate lines:
- the receive line fires once enough words have arrived;
- the transmit line fires once the queue has drained far enough.

In single-word mode the transmit line stays low. The receive line then carries two sources: a per-word completion event and a receive-overrun event. The overrun source only reaches the line on the clear-to-set edge of its flag.

Software sees three words on the bus:
- a data word;
- a control word holding the mode, the four enables and both thresholds;
- a status/command word. Reading it returns counts and flags. Writing it clears flags (write one to clear) and empties either queue.

Top module: `spi_fifo_irq`

## Requirements
- R1: Each queue holds DEPTH (16) words in arrival order with a fill count of 0..16. A pop of an empty queue has no effect. Writing address 0 pushes the transmit queue. Reading address 0 returns the receive head (0 when empty) and pops it. The transmit head appears on `eng_tx_data`, with `eng_tx_valid` high when the transmit queue is not empty.
- R2: An engine push into a full receive queue is dropped, the count stays 16, and the overflow flag (status bit 18) sets. Writing 1 to command bit 18 clears it.
- R3: The receive threshold flag (status bit 16) sets one cycle after the receive count is greater than or equal to the receive level. The receive level is control bits [12:8] and resets to 16.
- R4: The transmit threshold flag (status bit 17) sets one cycle after the transmit count is less than or equal to the transmit level. The transmit level is control bits [20:16] and resets to 0.
- R5: Both threshold flags are sticky. Writing 1 to command bit 16 or 17 clears the matching flag. The flag sets again on the following cycle if its condition still holds.
- R6: In queued mode (control bit 0 = 1), `irq_rx` is the receive flag gated by control bit 1, and `irq_tx` is the transmit flag gated by control bit 2.
- R7: In single-word mode (control bit 0 = 0), `irq_tx` is held low whatever the transmit flag and its enable are.
- R8: In single-word mode, every engine receive push sets the completion flag (status bit 19, cleared by command bit 19). While control bit 3 is 1, that flag drives `irq_rx`.
- R9: In single-word mode, an engine receive push while the receive count is non-zero sets the overrun flag (status bit 20, cleared by command bit 20).
  - The overrun raises `irq_rx` only if control bit 4 is 1 at the moment the flag goes from clear to set.
  - Enabling control bit 4 after the flag is already set does not raise the line.
  - Further overruns while the flag is still set do not raise the line.
- R10: Writing 1 to command bit 24 (receive) or command bit 25 (transmit) empties that queue and zeroes its count. Both thresholds are unchanged.
- R11: After reset:
  - counts and flags are 0, except that the transmit flag sets one cycle later;
  - the control word reads 0x00001000 (single-word mode, all enables off);
  - both interrupt lines are low.
- R12: Status field positions are receive count [4:0] and transmit count [12:8]. Address 1 is the control word, address 2 is status/command, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data (combinational) |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DW | Received word |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | DW | Transmit queue head |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| irq_rx | output | 1 | Receive line, or merged line in single-word mode |
| irq_tx | output | 1 | Transmit line (queued mode only) |

## Verification
The assertions assume four things about the inputs:
- strobes are held for whole clock cycles;
- a bus write and a bus read never target the queues in the same cycle;
- the engine does not pop the transmit queue in the cycle in which that queue is emptied;
- a threshold never exceeds the queue depth in the bench.

Only the overrun check allows a clear and a new overrun in the same cycle; it accepts a pending edge in that case.

The stimulus meets these assumptions by driving one strobe per task, changing inputs on the falling edge, and writing thresholds only between 0 and 16.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // control word bit positions
  localparam int unsigned C_MODE   = 0;
  localparam int unsigned C_RXIE   = 1;
  localparam int unsigned C_TXIE   = 2;
  localparam int unsigned C_DONEIE = 3;
  localparam int unsigned C_OVRIE  = 4;
  localparam int unsigned C_RXLVL  = 8;
  localparam int unsigned C_TXLVL  = 16;

  // status / command bit positions
  localparam int unsigned S_RXCNT  = 0;
  localparam int unsigned S_TXCNT  = 8;
  localparam int unsigned S_RXFLG  = 16;
  localparam int unsigned S_TXFLG  = 17;
  localparam int unsigned S_OVF    = 18;
  localparam int unsigned S_DONE   = 19;
  localparam int unsigned S_OVR    = 20;
  localparam int unsigned K_RXRST  = 24;
  localparam int unsigned K_TXRST  = 25;

endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          drop
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, push_ok, pop_ok;

  assign full    = (cnt_q == FULLC);
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign drop    = push & full & ~flush;
  assign dout    = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

endmodule

// File: rtl/sfi_level_flag.sv
module sfi_level_flag #(
  parameter int CW       = 5,
  parameter bit AT_ABOVE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] level,
  input  logic          clr,
  output logic          flag
);

  logic cond;
  logic flag_q, flag_d;

  generate
    if (AT_ABOVE) begin : g_above
      assign cond = (count >= level);
    end else begin : g_below
      assign cond = (count <= level);
    end
  endgenerate

  always_comb begin
    if (clr) flag_d = 1'b0;
    else     flag_d = flag_q | cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

endmodule

// File: rtl/sfi_legacy_irq.sv
module sfi_legacy_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic rx_push,
  input  logic rx_busy,
  input  logic ovr_ie,
  input  logic done_clr,
  input  logic ovr_clr,
  output logic done_flag,
  output logic ovr_flag,
  output logic ovr_pend
);

  logic done_q, done_d, ovr_q, ovr_d, pend_q, pend_d;
  logic word_in, ovr_set, ovr_edge;

  assign word_in  = ~fifo_mode & rx_push;
  assign ovr_set  = word_in & rx_busy;
  assign ovr_edge = ovr_set & (~ovr_q | ovr_clr);

  always_comb begin
    done_d = word_in | (done_q & ~done_clr);
    ovr_d  = ovr_set | (ovr_q & ~ovr_clr);
    pend_d = (ovr_edge & ovr_ie) | (pend_q & ~ovr_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      done_q <= done_d;
      ovr_q  <= ovr_d;
      pend_q <= pend_d;
    end
  end

  assign done_flag = done_q;
  assign ovr_flag  = ovr_q;
  assign ovr_pend  = pend_q;

endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data,
  output logic          eng_tx_valid,
  output logic          irq_rx,
  output logic          irq_tx
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] RXLVL_RST = CW'(DEPTH);

  reg_sel_e sel;
  logic ctrl_wr, cmd_wr, tx_push, rx_pop;
  logic rx_flush, tx_flush, rx_clr, tx_clr, ovf_clr, done_clr, ovr_clr;

  logic          mode_q, mode_d, rxie_q, rxie_d, txie_q, txie_d;
  logic          doneie_q, doneie_d, ovrie_q, ovrie_d;
  logic [CW-1:0] rx_lvl_q, rx_lvl_d, tx_lvl_q, tx_lvl_d;
  logic          ovf_q, ovf_d;

  logic [DW-1:0] rx_head;
  logic [CW-1:0] rx_count, tx_count;
  logic          rx_empty, tx_empty, rx_drop, tx_drop;
  logic          rx_flag, tx_flag;
  logic          done_flag, ovr_flag, ovr_pend;
  logic          legacy_irq;
  logic [31:0]   ctrl_word, stat_word;

  // bus decode
  assign sel      = reg_sel_e'(bus_addr);
  assign ctrl_wr  = bus_wr & (sel == SEL_CTRL);
  assign cmd_wr   = bus_wr & (sel == SEL_STAT);
  assign tx_push  = bus_wr & (sel == SEL_DATA);
  assign rx_pop   = bus_rd & (sel == SEL_DATA);
  assign rx_flush = cmd_wr & bus_wdata[K_RXRST];
  assign tx_flush = cmd_wr & bus_wdata[K_TXRST];
  assign rx_clr   = cmd_wr & bus_wdata[S_RXFLG];
  assign tx_clr   = cmd_wr & bus_wdata[S_TXFLG];
  assign ovf_clr  = cmd_wr & bus_wdata[S_OVF];
  assign done_clr = cmd_wr & bus_wdata[S_DONE];
  assign ovr_clr  = cmd_wr & bus_wdata[S_OVR];

  // control register
  always_comb begin
    mode_d   = mode_q;
    rxie_d   = rxie_q;
    txie_d   = txie_q;
    doneie_d = doneie_q;
    ovrie_d  = ovrie_q;
    rx_lvl_d = rx_lvl_q;
    tx_lvl_d = tx_lvl_q;
    if (ctrl_wr) begin
      mode_d   = bus_wdata[C_MODE];
      rxie_d   = bus_wdata[C_RXIE];
      txie_d   = bus_wdata[C_TXIE];
      doneie_d = bus_wdata[C_DONEIE];
      ovrie_d  = bus_wdata[C_OVRIE];
      rx_lvl_d = bus_wdata[C_RXLVL +: CW];
      tx_lvl_d = bus_wdata[C_TXLVL +: CW];
    end
  end

  always_comb begin
    ovf_d = rx_drop | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      rxie_q   <= 1'b0;
      txie_q   <= 1'b0;
      doneie_q <= 1'b0;
      ovrie_q  <= 1'b0;
      rx_lvl_q <= RXLVL_RST;
      tx_lvl_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      rxie_q   <= rxie_d;
      txie_q   <= txie_d;
      doneie_q <= doneie_d;
      ovrie_q  <= ovrie_d;
      rx_lvl_q <= rx_lvl_d;
      tx_lvl_q <= tx_lvl_d;
      ovf_q    <= ovf_d;
    end
  end

  // queues
  sfi_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (eng_rx_push),
    .din   (eng_rx_data),
    .pop   (rx_pop),
    .flush (rx_flush),
    .dout  (rx_head),
    .count (rx_count),
    .empty (rx_empty),
    .drop  (rx_drop)
  );

  sfi_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_push),
    .din   (bus_wdata[DW-1:0]),
    .pop   (eng_tx_pop),
    .flush (tx_flush),
    .dout  (eng_tx_data),
    .count (tx_count),
    .empty (tx_empty),
    .drop  (tx_drop)
  );

  // threshold flags
  sfi_level_flag #(.CW(CW), .AT_ABOVE(1'b1)) u_rxflag (
    .clk   (clk),
    .rst_n (rst_n),
    .count (rx_count),
    .level (rx_lvl_q),
    .clr   (rx_clr),
    .flag  (rx_flag)
  );

  sfi_level_flag #(.CW(CW), .AT_ABOVE(1'b0)) u_txflag (
    .clk   (clk),
    .rst_n (rst_n),
    .count (tx_count),
    .level (tx_lvl_q),
    .clr   (tx_clr),
    .flag  (tx_flag)
  );

  // single-word mode events
  sfi_legacy_irq u_legacy (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (mode_q),
    .rx_push   (eng_rx_push),
    .rx_busy   (~rx_empty),
    .ovr_ie    (ovrie_q),
    .done_clr  (done_clr),
    .ovr_clr   (ovr_clr),
    .done_flag (done_flag),
    .ovr_flag  (ovr_flag),
    .ovr_pend  (ovr_pend)
  );

  // interrupt routing
  assign legacy_irq   = (done_flag & doneie_q) | (ovr_pend & ovrie_q);
  assign irq_rx       = mode_q ? (rx_flag & rxie_q) : legacy_irq;
  assign irq_tx       = mode_q & tx_flag & txie_q;
  assign eng_tx_valid = ~tx_empty;

  // read data
  always_comb begin
    ctrl_word = '0;
    ctrl_word[C_MODE]         = mode_q;
    ctrl_word[C_RXIE]         = rxie_q;
    ctrl_word[C_TXIE]         = txie_q;
    ctrl_word[C_DONEIE]       = doneie_q;
    ctrl_word[C_OVRIE]        = ovrie_q;
    ctrl_word[C_RXLVL +: CW]  = rx_lvl_q;
    ctrl_word[C_TXLVL +: CW]  = tx_lvl_q;
  end

  always_comb begin
    stat_word = '0;
    stat_word[S_RXCNT +: CW] = rx_count;
    stat_word[S_TXCNT +: CW] = tx_count;
    stat_word[S_RXFLG]       = rx_flag;
    stat_word[S_TXFLG]       = tx_flag;
    stat_word[S_OVF]         = ovf_q;
    stat_word[S_DONE]        = done_flag;
    stat_word[S_OVR]         = ovr_flag;
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_DATA: if (!rx_empty) bus_rdata[DW-1:0] = rx_head;
      SEL_CTRL: bus_rdata = ctrl_word;
      SEL_STAT: bus_rdata = stat_word;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sfi_chk.sv
module sfi_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_lvl,
  input logic [CW-1:0] tx_lvl,
  input logic          rx_flag,
  input logic          tx_flag,
  input logic          rx_clr,
  input logic          tx_clr,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          rx_flush,
  input logic          ovf,
  input logic          ovr_flag,
  input logic          ovr_pend,
  input logic          ovr_clr
);

  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= FULLC) && (tx_count <= FULLC));

  // R2
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == FULLC && rx_push && !rx_pop && !rx_flush) |=> (rx_count == FULLC && ovf));

  // R3
  rx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count >= rx_lvl && !rx_clr) |=> rx_flag);

  // R4
  tx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= tx_lvl && !tx_clr) |=> tx_flag);

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> !rx_flag);

  // R9
  ovr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_pend) |-> (ovr_flag && ($past(!ovr_flag) || $past(ovr_clr))));

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_count == '0));

endmodule

bind spi_fifo_irq sfi_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_count (rx_count),
  .tx_count (tx_count),
  .rx_lvl   (rx_lvl_q),
  .tx_lvl   (tx_lvl_q),
  .rx_flag  (rx_flag),
  .tx_flag  (tx_flag),
  .rx_clr   (rx_clr),
  .tx_clr   (tx_clr),
  .rx_push  (eng_rx_push),
  .rx_pop   (rx_pop),
  .rx_flush (rx_flush),
  .ovf      (ovf_q),
  .ovr_flag (ovr_flag),
  .ovr_pend (ovr_pend),
  .ovr_clr  (ovr_clr)
);

// File: tb/spi_fifo_irq_tb.sv
module spi_fifo_irq_tb;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          eng_rx_push = 1'b0;
  logic [DW-1:0] eng_rx_data = '0;
  logic          eng_tx_pop = 1'b0;
  logic [DW-1:0] eng_tx_data;
  logic          eng_tx_valid;
  logic          irq_rx, irq_tx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_fifo_irq #(.DEPTH(16), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_tx_valid(eng_tx_valid),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;
  localparam logic [31:0] MODE = 32'h1, RXIE = 32'h2, TXIE = 32'h4,
                          DONEIE = 32'h8, OVRIE = 32'h10;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    eng_rx_push = 1'b1; eng_rx_data = d;
    tick();
    eng_rx_push = 1'b0;
  endtask

  task automatic tpop();
    eng_tx_pop = 1'b1;
    tick();
    eng_tx_pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R11 irq_rx", {31'd0, irq_rx}, 32'd0);
    chk("R11 irq_tx", {31'd0, irq_tx}, 32'd0);
    rd(A_CTRL, v); chk("R11 ctrl", v, 32'h0000_1000);
    rd(A_STAT, v); chk("R11 stat", v, 32'h0002_0000);
    rd(2'd3, v);   chk("R12 unused addr", v, 32'd0);
  endtask

  task automatic t_queues();
    logic [31:0] v;
    wr(A_CTRL, MODE | (32'd16 << 8));
    for (int i = 0; i < 16; i++) push(16'hA000 + 16'(i));
    rd(A_STAT, v); chk("R1 rx count full", {27'd0, v[4:0]}, 32'd16);
    push(16'hBEEF);
    rd(A_STAT, v);
    chk("R2 count after drop", {27'd0, v[4:0]}, 32'd16);
    chk("R2 overflow flag", {31'd0, v[18]}, 32'd1);
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, v);
      chk("R1 rx order", v, 32'hA000 + i);
    end
    rd(A_DATA, v); chk("R1 empty read", v, 32'd0);
    rd(A_STAT, v); chk("R1 empty pop ignored", {27'd0, v[4:0]}, 32'd0);
    wr(A_STAT, 32'h1 << 18);
    rd(A_STAT, v); chk("R2 overflow clear", {31'd0, v[18]}, 32'd0);
    for (int i = 0; i < 3; i++) wr(A_DATA, 32'h5A00 + i);
    for (int i = 0; i < 3; i++) begin
      chk("R1 tx valid", {31'd0, eng_tx_valid}, 32'd1);
      chk("R1 tx order", {16'd0, eng_tx_data}, 32'h5A00 + i);
      tpop();
    end
    chk("R1 tx drained", {31'd0, eng_tx_valid}, 32'd0);
  endtask

  task automatic t_rx_level();
    logic [31:0] v;
    wr(A_CTRL, MODE | RXIE | (32'd3 << 8));
    wr(A_STAT, (32'h1 << 24) | (32'h1 << 16));
    push(16'h1); push(16'h2); tick();
    chk("R3 below level", {31'd0, irq_rx}, 32'd0);
    push(16'h3); tick();
    chk("R3 R6 at level irq", {31'd0, irq_rx}, 32'd1);
    rd(A_STAT, v); chk("R3 flag bit", {31'd0, v[16]}, 32'd1);
    wr(A_STAT, 32'h1 << 16);
    chk("R5 cleared", {31'd0, irq_rx}, 32'd0);
    tick();
    chk("R5 re-set", {31'd0, irq_rx}, 32'd1);
    wr(A_CTRL, MODE | (32'd3 << 8));
    chk("R6 enable off", {31'd0, irq_rx}, 32'd0);
    wr(A_STAT, (32'h1 << 24) | (32'h1 << 16));
    tick();
    rd(A_STAT, v);
    chk("R5 stays clear", {v[16], v[4:0]}, 6'd0);
  endtask

  task automatic t_tx_level();
    logic [31:0] v;
    wr(A_CTRL, MODE | TXIE | (32'd16 << 8) | (32'd2 << 16));
    wr(A_STAT, 32'h1 << 25);
    for (int i = 0; i < 4; i++) wr(A_DATA, 32'h77 + i);
    wr(A_STAT, 32'h1 << 17);
    tick(); chk("R4 count 4 above", {31'd0, irq_tx}, 32'd0);
    tpop(); tick(); chk("R4 count 3 above", {31'd0, irq_tx}, 32'd0);
    tpop(); tick(); chk("R4 R6 count 2 at level", {31'd0, irq_tx}, 32'd1);
    wr(A_STAT, 32'h1 << 25);
    rd(A_STAT, v); chk("R10 tx emptied", {27'd0, v[12:8]}, 32'd0);
    rd(A_CTRL, v);
    chk("R10 levels kept", v, MODE | TXIE | (32'd16 << 8) | (32'd2 << 16));
  endtask

  task automatic t_single_word();
    logic [31:0] v;
    wr(A_CTRL, TXIE | DONEIE | (32'd16 << 8) | (32'd16 << 16));
    wr(A_STAT, 32'h031F_0000);
    tick();
    chk("R7 tx line low", {31'd0, irq_tx}, 32'd0);
    chk("R8 idle", {31'd0, irq_rx}, 32'd0);
    push(16'h11);
    chk("R8 done irq", {31'd0, irq_rx}, 32'd1);
    rd(A_STAT, v); chk("R8 done bit", {31'd0, v[19]}, 32'd1);
    wr(A_STAT, 32'h1 << 19);
    chk("R8 done cleared", {31'd0, irq_rx}, 32'd0);
    push(16'h22);
    rd(A_STAT, v); chk("R9 overrun bit", {30'd0, v[20], v[19]}, 32'd3);
    wr(A_CTRL, OVRIE | (32'd16 << 8) | (32'd16 << 16));
    chk("R9 late enable", {31'd0, irq_rx}, 32'd0);
    push(16'h33);
    chk("R9 no retrigger", {31'd0, irq_rx}, 32'd0);
    wr(A_STAT, (32'h1 << 20) | (32'h1 << 19));
    chk("R9 cleared", {31'd0, irq_rx}, 32'd0);
    push(16'h44);
    chk("R9 fresh overrun", {31'd0, irq_rx}, 32'd1);
    chk("R7 tx still low", {31'd0, irq_tx}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_queues();
    t_rx_level();
    t_tx_level();
    t_single_word();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule